// File: doc/BRIEF.md
# Multiple-Register Transfer Sequencer

This block takes one decoded multiple-register load or store and replays it as a series of single-word memory beats. It produces one beat for each register named in a 16-entry register list, together with that beat's word address and its direction. The next pipeline instruction is held in a stall for the whole run. When the run ends, the block may issue one write of the updated base address to the base register.

The caller presents the decoded fields and the current base register value together with a one-cycle `start`. The block captures all of them in that cycle. Each beat is then held on the beat outputs until memory accepts it through `mem_ready`. A final cycle raises `done` and, when the rules allow, `wb_en` with the new base value. Caches, the register file and operand forwarding are outside this block.

Top module: `blk_xfer_seq`

## Requirements
- R1: One beat is produced for each set bit of `reg_list`, in order from the lowest register index to the highest, and `beat_reg` carries that index.
- R2: Beat addresses rise by 4 from one beat to the next. With N set bits, the first address depends on `up` and `pre`: up=1,pre=0 gives base; up=1,pre=1 gives base+4; up=0,pre=0 gives base-4N+4; up=0,pre=1 gives base-4N.
- R3: `beat_write` is 1 on every beat of a store (`is_load`=0) and 0 on every beat of a load (`is_load`=1).
- R4: A beat whose cycle has `mem_ready` low is repeated unchanged in the next cycle.
- R5: `stall` is high from the cycle after `start` up to and including the `done` cycle, and low in the cycle after `done`.
- R6: `done` is a single-cycle pulse in the cycle after the last beat is accepted. An empty list gives no beats and raises `done` in the cycle right after `start`.
- R7: In the `done` cycle, `wb_val` equals base+4N when `up`=1 and base-4N when `up`=0.
- R8: `wb_en` is high only in the `done` cycle. It is high when N>0 and either `pre`=1 or `wb`=1, except on a load whose list includes `base_idx`, where it stays low.
- R9: A `start` that arrives while a run is in progress is ignored, and the current run's beats are unaffected.
- R10: After reset, `beat_valid`, `beat_write`, `wb_en`, `stall` and `done` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Decoded instruction valid; fields are captured in this cycle |
| base_idx | input | 4 | Index of the base register |
| reg_list | input | 16 | Bit i set means register i is transferred |
| up | input | 1 | 1: offset is added to the base; 0: offset is subtracted |
| pre | input | 1 | 1: offset is applied before the access; 0: after it |
| wb | input | 1 | Write-back request, which matters only when pre=0 |
| is_load | input | 1 | 1: load; 0: store |
| base_val | input | 32 | Current base register value |
| mem_ready | input | 1 | Memory accepts the beat shown in this cycle |
| beat_valid | output | 1 | A beat is presented |
| beat_reg | output | 4 | Register index of the current beat |
| beat_addr | output | 32 | Word address of the current beat |
| beat_write | output | 1 | Beat is a store |
| wb_en | output | 1 | Write `wb_val` to the base register |
| wb_val | output | 32 | Updated base address |
| stall | output | 1 | Hold the next pipeline instruction |
| done | output | 1 | Sequence finished |

## Verification
Several kinds of register list are applied. A single bit catches first-address and last-beat errors. Full and alternating lists test the scan order and the address stepping over a long run. An empty list separates the zero-beat path from the normal end of a run. Random lists run under all four up/pre combinations, with memory readiness ranging from always ready to mostly stalled, so the hold-while-not-ready behaviour is kept apart from the advance-on-ready behaviour. Loads that include the base register and post-indexed runs without write-back tell the suppression rule apart from the ordinary write-back rule. A `start` pulse sent in the middle of a run checks that the run in progress is left untouched.

// File: rtl/blk_xfer_pkg.sv
package blk_xfer_pkg;
   typedef enum logic [1:0] {
      SEQ_IDLE = 2'd0,
      SEQ_BEAT = 2'd1,
      SEQ_FIN  = 2'd2
   } seq_state_t;
endpackage

// File: rtl/bx_low_pick.sv
// Finds the lowest set bit of a vector and returns it as a one-hot mask and as an index.
module bx_low_pick #(
   parameter  int NREG = 16,
   localparam int IDXW = $clog2(NREG)
) (
   input  logic [NREG-1:0] vec,
   output logic [NREG-1:0] onehot,
   output logic [IDXW-1:0] idx,
   output logic            hit
);
   genvar gi;
   generate
      for (gi = 0; gi < NREG; gi++) begin : g_mask
         if (gi == 0) begin : g_first
            assign onehot[gi] = vec[gi];
         end else begin : g_rest
            assign onehot[gi] = vec[gi] & ~(|vec[gi-1:0]);
         end
      end
   endgenerate

   always_comb begin
      idx = '0;
      for (int i = 0; i < NREG; i++) begin
         if (onehot[i]) idx = idx | IDXW'(i);
      end
   end

   assign hit = |vec;
endmodule

// File: rtl/bx_pop_count.sv
// Counts the set bits of the register list.
module bx_pop_count #(
   parameter  int NREG = 16,
   localparam int CNTW = $clog2(NREG + 1)
) (
   input  logic [NREG-1:0] vec,
   output logic [CNTW-1:0] cnt
);
   always_comb begin
      cnt = '0;
      for (int i = 0; i < NREG; i++) begin
         cnt = cnt + CNTW'(vec[i]);
      end
   end
endmodule

// File: rtl/bx_addr_plan.sv
// Works out the first beat address and the final base value from the base, the word count and the mode bits.
module bx_addr_plan #(
   parameter  int NREG       = 16,
   parameter  int AW         = 32,
   parameter  int WORD_BYTES = 4,
   localparam int CNTW       = $clog2(NREG + 1),
   localparam int STEP_SH    = $clog2(WORD_BYTES)
) (
   input  logic [AW-1:0]   base,
   input  logic [CNTW-1:0] cnt,
   input  logic            up,
   input  logic            pre,
   output logic [AW-1:0]   first_addr,
   output logic [AW-1:0]   final_base
);
   localparam logic [AW-1:0] STEP = AW'(WORD_BYTES);
   logic [AW-1:0] span;
   logic [AW-1:0] low_end;

   assign span    = AW'(cnt) << STEP_SH;
   assign low_end = base - span;

   always_comb begin
      case ({up, pre})
         2'b10:   first_addr = base;
         2'b11:   first_addr = base + STEP;
         2'b00:   first_addr = low_end + STEP;
         default: first_addr = low_end;
      endcase
      final_base = up ? (base + span) : low_end;
   end
endmodule

// File: rtl/blk_xfer_seq.sv
module blk_xfer_seq
   import blk_xfer_pkg::*;
#(
   parameter  int NREG       = 16,
   parameter  int AW         = 32,
   parameter  int WORD_BYTES = 4,
   localparam int IDXW       = $clog2(NREG),
   localparam int CNTW       = $clog2(NREG + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic [IDXW-1:0] base_idx,
   input  logic [NREG-1:0] reg_list,
   input  logic            up,
   input  logic            pre,
   input  logic            wb,
   input  logic            is_load,
   input  logic [AW-1:0]   base_val,
   input  logic            mem_ready,
   output logic            beat_valid,
   output logic [IDXW-1:0] beat_reg,
   output logic [AW-1:0]   beat_addr,
   output logic            beat_write,
   output logic            wb_en,
   output logic [AW-1:0]   wb_val,
   output logic            stall,
   output logic            done
);
   localparam logic [AW-1:0] STEP = AW'(WORD_BYTES);

   generate
      if (NREG < 2 || (1 << IDXW) != NREG) begin : g_bad_nreg
         $error("NREG must be a power of two of at least 2");
      end
      if (WORD_BYTES < 1 || (1 << $clog2(WORD_BYTES)) != WORD_BYTES) begin : g_bad_word
         $error("WORD_BYTES must be a power of two");
      end
      if (AW < 8) begin : g_bad_aw
         $error("AW too narrow");
      end
   endgenerate

   seq_state_t      state_q;
   logic [NREG-1:0] rem_q;
   logic [AW-1:0]   addr_q;
   logic [AW-1:0]   wb_val_q;
   logic            wb_plan_q;
   logic            load_q;

   logic [CNTW-1:0] list_cnt;
   logic [AW-1:0]   first_addr;
   logic [AW-1:0]   final_base;
   logic [NREG-1:0] pick_mask;
   logic [IDXW-1:0] pick_idx;
   logic            pick_hit;
   logic            accept;
   logic            last_beat;
   logic            base_in_list;

   bx_pop_count #(.NREG(NREG)) u_pop (
      .vec (reg_list),
      .cnt (list_cnt)
   );

   bx_addr_plan #(.NREG(NREG), .AW(AW), .WORD_BYTES(WORD_BYTES)) u_plan (
      .base       (base_val),
      .cnt        (list_cnt),
      .up         (up),
      .pre        (pre),
      .first_addr (first_addr),
      .final_base (final_base)
   );

   bx_low_pick #(.NREG(NREG)) u_pick (
      .vec    (rem_q),
      .onehot (pick_mask),
      .idx    (pick_idx),
      .hit    (pick_hit)
   );

   assign base_in_list = reg_list[base_idx];
   assign accept       = (state_q == SEQ_BEAT) && mem_ready && pick_hit;
   assign last_beat    = (rem_q & ~pick_mask) == '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= SEQ_IDLE;
         rem_q     <= '0;
         addr_q    <= '0;
         wb_val_q  <= '0;
         wb_plan_q <= 1'b0;
         load_q    <= 1'b0;
      end else begin
         case (state_q)
            SEQ_IDLE: begin
               if (start) begin
                  rem_q     <= reg_list;
                  addr_q    <= first_addr;
                  wb_val_q  <= final_base;
                  load_q    <= is_load;
                  wb_plan_q <= (list_cnt != '0) && (pre || wb) && !(is_load && base_in_list);
                  state_q   <= (reg_list == '0) ? SEQ_FIN : SEQ_BEAT;
               end
            end
            SEQ_BEAT: begin
               if (accept) begin
                  rem_q  <= rem_q & ~pick_mask;
                  addr_q <= addr_q + STEP;
                  if (last_beat) state_q <= SEQ_FIN;
               end
            end
            SEQ_FIN: begin
               state_q   <= SEQ_IDLE;
               wb_plan_q <= 1'b0;
            end
            default: state_q <= SEQ_IDLE;
         endcase
      end
   end

   assign beat_valid = (state_q == SEQ_BEAT);
   assign beat_reg   = pick_idx;
   assign beat_addr  = addr_q;
   assign beat_write = beat_valid && !load_q;
   assign done       = (state_q == SEQ_FIN);
   assign wb_en      = done && wb_plan_q;
   assign wb_val     = wb_val_q;
   assign stall      = (state_q != SEQ_IDLE);
endmodule

// File: rtl/bx_seq_chk.sv
module bx_seq_chk #(
   parameter  int NREG       = 16,
   parameter  int AW         = 32,
   parameter  int WORD_BYTES = 4,
   localparam int IDXW       = $clog2(NREG)
) (
   input logic            clk,
   input logic            rst_n,
   input logic            mem_ready,
   input logic            beat_valid,
   input logic [IDXW-1:0] beat_reg,
   input logic [AW-1:0]   beat_addr,
   input logic            beat_write,
   input logic            wb_en,
   input logic            stall,
   input logic            done
);
   localparam logic [AW-1:0] STEP = AW'(WORD_BYTES);

   // R1
   reg_rising_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_valid && mem_ready) |=> (!beat_valid || beat_reg > $past(beat_reg)));

   // R2
   addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_valid && mem_ready) |=> (!beat_valid || beat_addr == $past(beat_addr) + STEP));

   // R4
   beat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_valid && !mem_ready) |=> (beat_valid && $stable(beat_addr) && $stable(beat_reg) && $stable(beat_write)));

   // R5
   stall_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_valid || done) |-> stall);

   // R5
   stall_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !stall);

   // R6
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R6
   done_no_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !beat_valid);

   // R8
   wb_only_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wb_en |-> done);

   // R3
   write_only_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      beat_write |-> beat_valid);
endmodule

bind blk_xfer_seq bx_seq_chk #(.NREG(NREG), .AW(AW), .WORD_BYTES(WORD_BYTES)) u_seq_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .mem_ready  (mem_ready),
   .beat_valid (beat_valid),
   .beat_reg   (beat_reg),
   .beat_addr  (beat_addr),
   .beat_write (beat_write),
   .wb_en      (wb_en),
   .stall      (stall),
   .done       (done)
);

// File: tb/blk_xfer_seq_test.sv
`timescale 1ns/1ps
module blk_xfer_seq_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [3:0]  base_idx = '0;
   logic [15:0] reg_list = '0;
   logic        up = 1'b0, pre = 1'b0, wb = 1'b0, is_load = 1'b0;
   logic [31:0] base_val = '0;
   logic        mem_ready = 1'b0;
   logic        beat_valid, beat_write, wb_en, stall, done;
   logic [3:0]  beat_reg;
   logic [31:0] beat_addr, wb_val;

   int n_checks = 0;
   int n_fails  = 0;
   bit finished = 0;

   always #10 clk = ~clk;

   blk_xfer_seq uut (
      .clk(clk), .rst_n(rst_n), .start(start), .base_idx(base_idx), .reg_list(reg_list),
      .up(up), .pre(pre), .wb(wb), .is_load(is_load), .base_val(base_val),
      .mem_ready(mem_ready), .beat_valid(beat_valid), .beat_reg(beat_reg),
      .beat_addr(beat_addr), .beat_write(beat_write), .wb_en(wb_en), .wb_val(wb_val),
      .stall(stall), .done(done)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic int popc(input logic [15:0] v);
      int c = 0;
      for (int i = 0; i < 16; i++) c += int'(v[i]);
      return c;
   endfunction

   function automatic logic [31:0] exp_first(input logic [31:0] b, input int n, input logic u, input logic p);
      logic [31:0] span = 32'(n) * 32'd4;
      if (u) return p ? b + 32'd4 : b;
      return p ? b - span : b - span + 32'd4;
   endfunction

   task automatic run_op(input logic [15:0] lst, input logic [3:0] bidx, input logic u, input logic p,
                         input logic w, input logic l, input logic [31:0] b, input int rdy_pct,
                         input bit poke);
      int n = popc(lst);
      int k = 0;
      int cyc = 0;
      int last_acc = -1;
      bit fin = 0;
      int regs[16];
      logic [31:0] a0 = exp_first(b, n, u, p);
      logic [31:0] wexp = u ? b + 32'(n) * 32'd4 : b - 32'(n) * 32'd4;
      bit wb_exp = (n != 0) && (p || w) && !(l && lst[bidx]);
      begin
         int j = 0;
         for (int i = 0; i < 16; i++) if (lst[i]) begin regs[j] = i; j++; end
      end
      @(negedge clk);
      reg_list = lst; base_idx = bidx; up = u; pre = p; wb = w; is_load = l; base_val = b;
      start = 1'b1; mem_ready = 1'b0;
      @(negedge clk);
      start = 1'b0;
      while (!fin && cyc < 500) begin
         check(stall == 1'b1, "R5 stall during run", 32'(stall), 32'd1);
         if (beat_valid) begin
            check(k < n, "R1 beat count", 32'(k), 32'(n));
            if (k < n) begin
               check(beat_reg == 4'(regs[k]), "R1 register order", 32'(beat_reg), 32'(regs[k]));
               check(beat_addr == a0 + 32'(k) * 32'd4, "R2 beat address", beat_addr, a0 + 32'(k) * 32'd4);
               // R9: poked start must not disturb these values
               check(beat_write == !l, "R3 direction", 32'(beat_write), 32'(!l));
            end
            mem_ready = (($urandom % 100) < rdy_pct);
            if (mem_ready) begin k++; last_acc = cyc; end
         end else begin
            mem_ready = 1'b0;
         end
         if (done) begin
            fin = 1;
            check(k == n, "R1 beats delivered", 32'(k), 32'(n));
            check(cyc == last_acc + 1, "R6 done timing", 32'(cyc), 32'(last_acc + 1));
            check(wb_en == wb_exp, "R8 writeback enable", 32'(wb_en), 32'(wb_exp));
            if (n != 0) check(wb_val == wexp, "R7 writeback value", wb_val, wexp);
         end else begin
            check(wb_en == 1'b0, "R8 wb outside done", 32'(wb_en), 32'd0);
         end
         if (poke && cyc == 1) begin
            start = 1'b1; reg_list = ~lst; base_val = ~b; is_load = ~l;
         end else begin
            start = 1'b0;
         end
         cyc++;
         @(negedge clk);
      end
      mem_ready = 1'b0;
      start = 1'b0;
      check(fin, "R6 run finished", 32'(fin), 32'd1);
      check(stall == 1'b0 && done == 1'b0, "R5 release after done", {30'd0, stall, done}, 32'd0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      // R10 reset state
      check({beat_valid, beat_write, wb_en, stall, done} == 5'd0, "R10 reset outputs",
            32'({beat_valid, beat_write, wb_en, stall, done}), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check({beat_valid, stall, done} == 3'd0, "R10 idle after reset", 32'({beat_valid, stall, done}), 32'd0);

      // directed corners
      run_op(16'h0000, 4'd3, 1'b1, 1'b1, 1'b1, 1'b0, 32'h0000_1000, 100, 0); // R6 empty list
      run_op(16'h0001, 4'd5, 1'b1, 1'b0, 1'b0, 1'b1, 32'h0000_2000, 100, 0); // R8 post no W
      run_op(16'h8000, 4'd0, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0000_3000, 50, 0);  // R2 down-before
      run_op(16'hFFFF, 4'd2, 1'b1, 1'b0, 1'b1, 1'b0, 32'h0000_4000, 100, 0); // R1 full list
      run_op(16'hAAAA, 4'd1, 1'b0, 1'b0, 1'b1, 1'b1, 32'h0000_5000, 30, 0);  // R2 down-after
      run_op(16'h00F0, 4'd5, 1'b1, 1'b1, 1'b0, 1'b1, 32'h0000_6000, 100, 0); // R8 base loaded
      run_op(16'h00F0, 4'd5, 1'b1, 1'b1, 1'b0, 1'b0, 32'h0000_6000, 100, 0); // R8 base stored
      run_op(16'h0F0F, 4'd9, 1'b1, 1'b1, 1'b1, 1'b0, 32'h0000_7000, 20, 1);  // R9 start while busy
      run_op(16'h0002, 4'd0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0000_0000, 10, 0);  // R4 slow ready, wrap

      for (int t = 0; t < 300; t++) begin
         logic [15:0] lst = 16'($urandom);
         if (t % 17 == 0) lst = '0;
         run_op(lst, 4'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                $urandom & 32'hFFFF_FFFC, 20 + int'($urandom % 81), (popc(lst) >= 3) && (t % 5 == 0));
      end

      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end
endmodule